// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block holds the modem-handshake side of one serial channel. A control byte, written by the host, sets the four active-low handshake outputs: terminal-ready, request-to-send and two general-purpose outputs. One more bit of that byte turns on a self-test loopback. A status byte, read by the host, reports the current state of the four incoming handshake lines, clear-to-send, data-set-ready, ring and carrier. It also holds four sticky change flags, and an interrupt request stays raised while any of those flags is set.

The incoming lines are asynchronous and active low. Each passes through a synchronizer of `SYNC_STAGES` flops, and the status bits report the asserted sense of each line, which is the inverse of the pin level. Carrier, data-set-ready and clear-to-send flag every change. The ring flag sets only when a ring pulse ends, that is when the pin returns from low to high. A status read clears all four flags. A change detected on the same clock edge as the read still sets its flag.

In loopback the four outputs are held at their inactive high level. The control bits then act as the incoming lines: terminal-ready acts as data-set-ready, request-to-send as clear-to-send, the first general output as ring and the second as carrier. The external input pins have no effect while loopback is on.

Top module: `modem_ctl_stat`

## Requirements
- R1: Control byte bits 0..3 drive dtr_n, rts_n, out1_n and out2_n. A 1 in a bit drives its pin low and a 0 drives it high, from the clock edge that captures the write onward. ctrl_q reads back bits 4..0 as written, and bits 7..5 always read 0.
- R2: Status bits 7, 6, 5 and 4 show carrier, ring, data-set-ready and clear-to-send as the inverse of the dcd_n, ri_n, dsr_n and cts_n pins. A pin change appears in the status two clock edges after it is applied.
- R3: Status bits 3, 1 and 0 set when carrier, data-set-ready or clear-to-send respectively change in either direction. Each flag sets one edge after the matching current bit changes.
- R4: Status bit 2 sets only when ri_n goes from low to high. A high-to-low change of ri_n leaves it at 0.
- R5: A cycle with rd_stat high clears all four change flags on that edge. A change detected on the same edge still sets its flag.
- R6: msi_req is 1 exactly while at least one change flag is 1.
- R7: With control bit 4 set, all four output pins are held high whatever bits 0..3 hold.
- R8: With control bit 4 set, status bits 5, 4, 6 and 7 follow control bits 0, 1, 2 and 3 one edge after the write, and change flags derive from those values. The external input pins are ignored.
- R9: After reset the control byte is 0, all output pins are high, and the change flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte data |
| rd_stat | input | 1 | Status read strobe; clears change flags |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier pin, active low, asynchronous |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| ctrl_q | output | 8 | Control byte read-back |
| stat_q | output | 8 | Status byte |
| msi_req | output | 1 | Modem status interrupt request |

## Verification
A control write shows on ctrl_q and the pins one edge after the strobe is sampled. A pin change reaches the status bits after two edges and sets its flag on the third. In loopback a control write reaches the status bits after one edge and the flags on the second. The bench drives inputs and samples outputs at falling edges and waits exactly these counts before it compares. A status read is compared while the strobe is still high, before the clearing edge, and the bench checks again just after that edge that the flags are zero. A case with a change and a read on the same edge checks that the flag is kept.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;
  localparam int CTL_W    = 5;
  localparam int NLINES   = 4;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [CTL_W-1:0] ctl,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n
);
  logic [CTL_W-1:0] ctl_q, ctl_nx;
  logic             loop_on;

  always_comb begin
    ctl_nx = ctl_q;
    if (wr_en) ctl_nx = wr_data[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_nx;
  end

  assign loop_on = ctl_q[CTL_LOOP];
  assign ctl     = ctl_q;
  assign dtr_n   = loop_on | ~ctl_q[CTL_DTR];
  assign rts_n   = loop_on | ~ctl_q[CTL_RTS];
  assign out1_n  = loop_on | ~ctl_q[CTL_OUT1];
  assign out2_n  = loop_on | ~ctl_q[CTL_OUT2];
endmodule

// File: rtl/mdm_change_det.sv
module mdm_change_det
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mdm_lines_t        cur,
  input  logic              rd_clr,
  output logic [NLINES-1:0] flags
);
  mdm_lines_t        prev_q;
  logic [NLINES-1:0] flags_q, flags_nx, set_v;

  always_comb begin
    set_v[3] = cur.dcd ^ prev_q.dcd;
    set_v[2] = prev_q.ri & ~cur.ri;
    set_v[1] = cur.dsr ^ prev_q.dsr;
    set_v[0] = cur.cts ^ prev_q.cts;
    flags_nx = set_v | (flags_q & ~{NLINES{rd_clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= cur;
      flags_q <= flags_nx;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  input  logic       rd_stat,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  output logic [7:0] ctrl_q,
  output logic [7:0] stat_q,
  output logic       msi_req
);
  logic [CTL_W-1:0]  ctl;
  logic [NLINES-1:0] pins_raw, pins_sync, flags;
  mdm_lines_t        ext_lines, loop_lines, cur;

  mdm_ctrl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wr_data(wr_data),
    .ctl(ctl), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  assign pins_raw = {dcd_n, ri_n, dsr_n, cts_n};

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync)
  );

  always_comb begin
    ext_lines      = mdm_lines_t'(~pins_sync);
    loop_lines.dcd = ctl[CTL_OUT2];
    loop_lines.ri  = ctl[CTL_OUT1];
    loop_lines.dsr = ctl[CTL_DTR];
    loop_lines.cts = ctl[CTL_RTS];
    cur            = ctl[CTL_LOOP] ? loop_lines : ext_lines;
  end

  mdm_change_det u_chg (
    .clk(clk), .rst_n(rst_n), .cur(cur), .rd_clr(rd_stat), .flags(flags)
  );

  assign ctrl_q  = {{(8-CTL_W){1'b0}}, ctl};
  assign stat_q  = {cur.dcd, cur.ri, cur.dsr, cur.cts, flags};
  assign msi_req = |flags;
endmodule

// File: rtl/mdm_checker.sv
module mdm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stat,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic [7:0] ctrl_q,
  input logic [7:0] stat_q
);
  AST_PINS_FOLLOW_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> ({out2_n, out1_n, rts_n, dtr_n} == ~ctrl_q[3:0])); // R1

  AST_TERI_TRAILING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[2]) |-> ($past(stat_q[6], 2) && !$past(stat_q[6]))); // R4

  AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && $stable(stat_q[7:4])) |=> (stat_q[3:0] == 4'h0)); // R5

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> (dtr_n && rts_n && out1_n && out2_n)); // R7
endmodule

bind modem_ctl_stat mdm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat),
  .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
  .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/sim_modem_ctl_stat.sv
`timescale 1ns/1ps
module sim_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_stat = 1'b0;
  logic [3:0] pins = 4'hF; // {dcd_n, ri_n, dsr_n, cts_n}
  logic       dtr_n, rts_n, out1_n, out2_n, msi_req;
  logic [7:0] ctrl_q, stat_q;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  modem_ctl_stat u0 (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .rd_stat(rd_stat), .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]),
    .dcd_n(pins[3]), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
    .out2_n(out2_n), .ctrl_q(ctrl_q), .stat_q(stat_q), .msi_req(msi_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_ctrl = 1'b1; wr_data = d;
    step(1);
    wr_ctrl = 1'b0;
  endtask

  // read the status: compare before the clearing edge, then confirm cleared
  task automatic rd_check(input logic [7:0] exp, input string req);
    rd_stat = 1'b1;
    #1;
    chk({24'h0, stat_q}, {24'h0, exp}, req);
    chk({31'h0, msi_req}, {31'h0, |exp[3:0]}, "R6 msi_req");
    step(1);
    rd_stat = 1'b0;
    #1;
    chk({28'h0, stat_q[3:0]}, 32'h0, "R5 flags after read");
    chk({31'h0, msi_req}, 32'h0, "R6 msi_req after read");
  endtask

  function automatic logic [7:0] expect_stat(input logic [3:0] from_n, input logic [3:0] to_n);
    logic [3:0] a0, a1, fl;
    a0 = ~from_n; a1 = ~to_n;
    fl[3] = a0[3] ^ a1[3];
    fl[2] = a0[2] & ~a1[2];
    fl[1] = a0[1] ^ a1[1];
    fl[0] = a0[0] ^ a1[0];
    return {a1, fl};
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    #1;
    // R9 reset state
    chk({24'h0, ctrl_q}, 32'h0, "R9 ctrl_q");
    chk({28'h0, dtr_n, rts_n, out1_n, out2_n}, 32'hF, "R9 pins");
    chk({24'h0, stat_q}, 32'h0, "R9 stat_q");
    chk({31'h0, msi_req}, 32'h0, "R9 msi_req");

    // R1 control writes, upper bits dropped
    wr(8'h0F); #1;
    chk({24'h0, ctrl_q}, 32'h0F, "R1 ctrl_q");
    chk({28'h0, out2_n, out1_n, rts_n, dtr_n}, 32'h0, "R1 pins low");
    wr(8'hE5); #1;
    chk({24'h0, ctrl_q}, 32'h05, "R1 ctrl_q upper zero");
    chk({28'h0, out2_n, out1_n, rts_n, dtr_n}, 32'hA, "R1 pins mixed");
    wr(8'h00);

    // R2 R3 R4 all transitions between pin patterns
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 16; t++) begin
        pins = 4'(f);
        step(3);
        rd_stat = 1'b1; step(1); rd_stat = 1'b0;
        pins = 4'(t);
        step(2); #1;
        chk({28'h0, stat_q[7:4]}, {28'h0, ~4'(t)}, "R2 status after two edges");
        step(1);
        rd_check(expect_stat(4'(f), 4'(t)), "R3 R4 change flags");
      end
    end

    // R5 change on the same edge as the read
    pins = 4'h0; step(3);
    rd_stat = 1'b1; step(1); rd_stat = 1'b0;
    pins = 4'h8;
    step(2);
    rd_stat = 1'b1; #1;
    chk({24'h0, stat_q}, 32'h70, "R5 read value same edge");
    step(1); rd_stat = 1'b0; #1;
    chk({24'h0, stat_q}, 32'h78, "R5 flag kept after read");
    chk({31'h0, msi_req}, 32'h1, "R6 msi_req set");
    step(1);
    rd_check(8'h78, "R5 flag read");

    // R7 R8 loopback
    pins = 4'hF; step(3);
    rd_stat = 1'b1; step(1); rd_stat = 1'b0;
    wr(8'h10);
    rd_stat = 1'b1; step(1); rd_stat = 1'b0;
    #1;
    chk({28'h0, dtr_n, rts_n, out1_n, out2_n}, 32'hF, "R7 pins idle in loop");
    pins = 4'h0; step(3); #1;
    chk({24'h0, stat_q}, 32'h00, "R8 pins ignored in loop");
    wr(8'h1F); #1;
    chk({28'h0, stat_q[7:4]}, 32'hF, "R8 loop status");
    chk({28'h0, dtr_n, rts_n, out1_n, out2_n}, 32'hF, "R7 pins idle all set");
    step(1);
    rd_check(8'hFB, "R8 loop flags rise");
    wr(8'h1B); step(1);
    rd_check(8'hB4, "R8 R4 loop ring trailing");
    wr(8'h11); step(1);
    rd_check(8'h29, "R8 loop dtr only");
    wr(8'h00); step(1);
    rd_check(8'hF9, "R8 exit loop to pins");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule